// File: doc/BRIEF.md
# Byte-Serial Microcoded Sixteen-Bit Register Engine

This block runs sixteen-bit register instructions on a datapath that is only one byte wide. Each opcode byte read from memory goes straight into a micro-program counter and names the micro-routine that follows. No separate decode stage sits in between. Sixteen-bit values pass through an accumulator held as a low half and a high half. All arithmetic goes through a single eight-bit adder, one half per step, and the carry is held between the two halves.

The register file lives in the same byte-wide memory that holds program and data. Register Rn sits at the workspace base plus 2n (low byte) and plus 2n+1 (high byte). The program counter is architecturally register R7 and is mirrored in a private address register. Two instructions exist:
- Load an 8-bit immediate into a register, zero-extended.
- Add a 16-bit memory operand at index base plus displacement into a register.

In the add, a second instruction byte redirects the micro-flow partway through. After every instruction a four-part routine forms the next program counter. It writes that value back to R7 and fetches the next opcode.

Top module: `bmc_core`

## Requirements
- R1: While reset is held, bus_rd, bus_wr and halted are 0. After release, the first bus read is at address 0x0000.
- R2: An opcode byte read at the PC is taken into the micro-program counter the cycle after the read is requested. Legal first bytes are 0x50–0x57 (immediate load, bits 2:0 = n) and 0x60–0x67 (indexed add, bits 2:0 = displacement d). The add's second byte, read at PC|1, must be 0x70–0x77 (bits 2:0 = n).
- R3: The immediate load reads the byte at PC|1. It writes that byte to address ws_base+2n and writes 0x00 to ws_base+2n+1.
- R4: The indexed add reads a little-endian word at idx_base+d and idx_base+d+1. It adds Rn modulo 2^16, carrying from the low-byte add into the high-byte add, and writes the sum back to Rn.
- R5: A register is written one byte per cycle, low byte first and high byte in the next cycle. A read and a write never share a cycle.
- R6: After each instruction the new PC is formed as follows. The high byte is the value of R7's high byte once the instruction has finished. The low byte is (old PC low + 2) mod 256, with no carry into the high byte. The new PC is written to R7 (low byte, then high byte), and the next opcode is read at that address.
- R7: Every opcode fetch address is even.
- R8: The next opcode read comes 10 cycles after the current opcode read for an immediate load, and 15 cycles after it for an indexed add.
- R9: An illegal first byte raises halted two cycles after its read and keeps it high. From then on there is no bus read, no bus write and no register change.
- R10: An illegal second byte in an add raises halted one cycle after the cycle in which that byte is taken. No register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ws_base | input | 16 | Workspace base byte address |
| idx_base | input | 16 | Index base for the indexed operand |
| bus_addr | output | 16 | Memory byte address |
| bus_rd | output | 1 | Read request; data is expected on bus_rdata one cycle later |
| bus_wr | output | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | output | 8 | Write data byte |
| bus_rdata | input | 8 | Read data byte, valid the cycle after bus_rd |
| halted | output | 1 | Illegal opcode seen; the engine is stopped |

## Verification
The bench first locates the cycle of an opcode read. Every later result is timed from that cycle:
- The next opcode read falls exactly 10 (load) or 15 (add) cycles later.
- halted appears 2 cycles after an illegal first byte is read, and 6 cycles after the read of an add's first byte when its second byte is illegal.
- Register and R7 contents are read from the memory model only after their write cycles have passed.

All outputs are sampled on the falling edge. Each check therefore sees the state that the preceding rising edge settled.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2 * BYTE_W;
  localparam int FLD_W    = 3;
  localparam int STEP_W   = 3;
  localparam logic [FLD_W-1:0] PC_REG_IDX = 3'd7;

  localparam logic [BYTE_W-1:0] UPC_FETCH = 8'hF0;
  localparam logic [BYTE_W-1:0] UPC_PCU   = 8'hF8;
  localparam logic [BYTE_W-1:0] UPC_HALT  = 8'hFF;

  localparam logic [BYTE_W-FLD_W-1:0] OPC_MOVI = 5'b01010;
  localparam logic [BYTE_W-FLD_W-1:0] OPC_ADDX = 5'b01100;
  localparam logic [BYTE_W-FLD_W-1:0] OPC_ADDR = 5'b01110;

  typedef enum logic [2:0] {
    AS_PC, AS_PC1, AS_X, AS_X1, AS_RLO, AS_RHI, AS_R7LO, AS_R7HI
  } asel_t;

  typedef enum logic [2:0] {
    AC_NONE, AC_LD_LO_CLR, AC_LD_LO, AC_LD_HI, AC_ADD_LO, AC_ADD_HI, AC_PC_INC
  } acop_t;

  typedef enum logic [2:0] {
    SQ_NEXT, SQ_TO_PCU, SQ_TO_FETCH1, SQ_DISP1, SQ_DISP2, SQ_HOLD
  } sq_t;

  typedef struct packed {
    asel_t asel;
    logic  rd;
    logic  wr;
    logic  wsel_hi;
    acop_t acop;
    logic  pc_ld;
    sq_t   sq;
    logic  halt;
  } uword_t;
endpackage

// File: rtl/bmc_adder.sv
module bmc_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;
  always_comb full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/bmc_agen.sv
module bmc_agen
  import bmc_pkg::*;
(
  input  asel_t              asel,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  idx_base,
  input  logic [ADDR_W-1:0]  ws_base,
  input  logic [FLD_W-1:0]   fld,
  output logic [ADDR_W-1:0]  addr
);
  localparam int PAD = ADDR_W - FLD_W - 1;
  logic [ADDR_W-1:0] disp, roff, r7off;

  always_comb begin
    disp  = {{(ADDR_W-FLD_W){1'b0}}, fld};
    roff  = {{PAD{1'b0}}, fld, 1'b0};
    r7off = {{PAD{1'b0}}, PC_REG_IDX, 1'b0};
    case (asel)
      AS_PC:   addr = pc;
      AS_PC1:  addr = {pc[ADDR_W-1:1], 1'b1};
      AS_X:    addr = idx_base + disp;
      AS_X1:   addr = idx_base + disp + 1'b1;
      AS_RLO:  addr = ws_base + roff;
      AS_RHI:  addr = ws_base + roff + 1'b1;
      AS_R7LO: addr = ws_base + r7off;
      default: addr = ws_base + r7off + 1'b1;
    endcase
  end
endmodule

// File: rtl/bmc_ucode.sv
module bmc_ucode
  import bmc_pkg::*;
(
  input  logic [BYTE_W-1:0] upc,
  input  logic [STEP_W-1:0] step,
  output uword_t            uw
);
  always_comb begin
    uw.asel    = AS_PC;
    uw.rd      = 1'b0;
    uw.wr      = 1'b0;
    uw.wsel_hi = 1'b0;
    uw.acop    = AC_NONE;
    uw.pc_ld   = 1'b0;
    uw.sq      = SQ_NEXT;
    uw.halt    = 1'b0;
    if (upc == UPC_FETCH) begin
      if (step == '0) uw.rd = 1'b1;
      else            uw.sq = SQ_DISP1;
    end else if (upc == UPC_PCU) begin
      case (step)
        3'd0: begin uw.acop = AC_PC_INC; uw.asel = AS_R7HI; uw.rd = 1'b1; end
        3'd1: uw.acop = AC_LD_HI;
        3'd2: begin uw.pc_ld = 1'b1; uw.wr = 1'b1; uw.asel = AS_R7LO; end
        3'd3: begin uw.wr = 1'b1; uw.wsel_hi = 1'b1; uw.asel = AS_R7HI; end
        default: begin uw.rd = 1'b1; uw.asel = AS_PC; uw.sq = SQ_TO_FETCH1; end
      endcase
    end else begin
      case (upc[BYTE_W-1:FLD_W])
        OPC_MOVI: case (step)
          3'd0: begin uw.asel = AS_PC1; uw.rd = 1'b1; end
          3'd1: uw.acop = AC_LD_LO_CLR;
          3'd2: begin uw.asel = AS_RLO; uw.wr = 1'b1; end
          default: begin
            uw.asel = AS_RHI; uw.wr = 1'b1; uw.wsel_hi = 1'b1; uw.sq = SQ_TO_PCU;
          end
        endcase
        OPC_ADDX: case (step)
          3'd0: begin uw.asel = AS_X; uw.rd = 1'b1; end
          3'd1: begin uw.acop = AC_LD_LO; uw.asel = AS_X1; uw.rd = 1'b1; end
          3'd2: begin uw.acop = AC_LD_HI; uw.asel = AS_PC1; uw.rd = 1'b1; end
          default: uw.sq = SQ_DISP2;
        endcase
        OPC_ADDR: case (step)
          3'd0: begin uw.asel = AS_RLO; uw.rd = 1'b1; end
          3'd1: begin uw.acop = AC_ADD_LO; uw.asel = AS_RHI; uw.rd = 1'b1; end
          3'd2: uw.acop = AC_ADD_HI;
          3'd3: begin uw.asel = AS_RLO; uw.wr = 1'b1; end
          default: begin
            uw.asel = AS_RHI; uw.wr = 1'b1; uw.wsel_hi = 1'b1; uw.sq = SQ_TO_PCU;
          end
        endcase
        default: begin uw.halt = 1'b1; uw.sq = SQ_HOLD; end
      endcase
    end
  end
endmodule

// File: rtl/bmc_core.sv
module bmc_core
  import bmc_pkg::*;
#(
  parameter int PC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ws_base,
  input  logic [ADDR_W-1:0] idx_base,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              halted
);
  localparam logic [BYTE_W-1:0] PC_INC_K = BYTE_W'(PC_STEP);

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [BYTE_W-1:0] acc_lo_q, acc_lo_d, acc_hi_q, acc_hi_d;
  logic              cy_q, cy_d;
  logic [BYTE_W-1:0] upc_q, upc_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              upc_en;

  uword_t            uw;
  logic [BYTE_W-1:0] add_a, add_b, add_sum;
  logic              add_cin, add_cout;
  logic              lgl_first, lgl_second;

  bmc_ucode u_ucode (.upc(upc_q), .step(step_q), .uw(uw));

  bmc_agen u_agen (
    .asel(uw.asel), .pc(pc_q), .idx_base(idx_base), .ws_base(ws_base),
    .fld(upc_q[FLD_W-1:0]), .addr(bus_addr)
  );

  bmc_adder #(.W(BYTE_W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin), .sum(add_sum), .cout(add_cout)
  );

  always_comb begin
    add_a   = acc_lo_q;
    add_b   = bus_rdata;
    add_cin = 1'b0;
    case (uw.acop)
      AC_ADD_HI: begin add_a = acc_hi_q; add_cin = cy_q; end
      AC_PC_INC: begin add_a = PC_INC_K; add_b = pc_q[BYTE_W-1:0]; end
      default: ;
    endcase
  end

  always_comb begin
    lgl_first  = (bus_rdata[BYTE_W-1:FLD_W] == OPC_MOVI) ||
                 (bus_rdata[BYTE_W-1:FLD_W] == OPC_ADDX);
    lgl_second = (bus_rdata[BYTE_W-1:FLD_W] == OPC_ADDR);
  end

  always_comb begin
    pc_d     = pc_q;
    acc_lo_d = acc_lo_q;
    acc_hi_d = acc_hi_q;
    cy_d     = cy_q;
    upc_d    = upc_q;
    step_d   = step_q;
    case (uw.acop)
      AC_LD_LO_CLR: begin acc_lo_d = bus_rdata; acc_hi_d = '0; end
      AC_LD_LO:     acc_lo_d = bus_rdata;
      AC_LD_HI:     acc_hi_d = bus_rdata;
      AC_ADD_LO:    begin acc_lo_d = add_sum; cy_d = add_cout; end
      AC_ADD_HI:    acc_hi_d = add_sum;
      AC_PC_INC:    acc_lo_d = add_sum;
      default: ;
    endcase
    if (uw.pc_ld) pc_d = {acc_hi_q, acc_lo_q};
    case (uw.sq)
      SQ_NEXT:      step_d = step_q + 1'b1;
      SQ_TO_PCU:    begin upc_d = UPC_PCU; step_d = '0; end
      SQ_TO_FETCH1: begin upc_d = UPC_FETCH; step_d = STEP_W'(1); end
      SQ_DISP1:     begin upc_d = lgl_first  ? bus_rdata : UPC_HALT; step_d = '0; end
      SQ_DISP2:     begin upc_d = lgl_second ? bus_rdata : UPC_HALT; step_d = '0; end
      default: ;
    endcase
  end

  assign upc_en = rst_s && !uw.halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      acc_lo_q <= '0;
      acc_hi_q <= '0;
      cy_q     <= 1'b0;
      upc_q    <= UPC_FETCH;
      step_q   <= '0;
    end else if (upc_en) begin
      pc_q     <= pc_d;
      acc_lo_q <= acc_lo_d;
      acc_hi_q <= acc_hi_d;
      cy_q     <= cy_d;
      upc_q    <= upc_d;
      step_q   <= step_d;
    end
  end

  assign bus_rd    = uw.rd && rst_s;
  assign bus_wr    = uw.wr && rst_s;
  assign bus_wdata = uw.wsel_hi ? acc_hi_q : acc_lo_q;
  assign halted    = (upc_q == UPC_HALT);

  // R5: one bus direction per cycle
  p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_s)
    !(bus_rd && bus_wr));

  // R5: a high-byte write follows the low-byte write one cycle earlier
  p_hi_after_lo_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && uw.wsel_hi) |-> ($past(bus_wr) && ($past(bus_addr) + 1'b1 == bus_addr)));

  // R7: opcode fetch addresses are even
  p_fetch_even_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_rd && ((upc_q == UPC_FETCH && step_q == '0) ||
                (upc_q == UPC_PCU && step_q == STEP_W'(4)))) |-> !bus_addr[0]);

  // R9: halt is sticky
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
    halted |=> halted);

  // R9: halted engine leaves the bus alone
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s)
    halted |-> (!bus_rd && !bus_wr));
endmodule

// File: tb/bmc_core_tb_top.sv
`timescale 1ns/1ps
module bmc_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] ws_base, idx_base, bus_addr;
  logic        bus_rd, bus_wr, halted;
  logic [7:0]  bus_wdata, bus_rdata;

  localparam logic [15:0] WSB = 16'h0100;
  localparam logic [15:0] IXB = 16'h0140;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]  mem [0:511];
  logic [15:0] wr_log [0:1023];
  int          wr_total = 0;

  bmc_core dut_i (
    .clk(clk), .rst_n(rst_n), .ws_base(ws_base), .idx_base(idx_base),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halted(halted)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= mem[bus_addr[8:0]];
    if (bus_wr) begin
      mem[bus_addr[8:0]] = bus_wdata;
      wr_log[wr_total % 1024] = bus_addr;
      wr_total = wr_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  task automatic put16(input logic [15:0] a, input logic [15:0] v);
    mem[a[8:0]]        = v[7:0];
    mem[a[8:0] + 9'd1] = v[15:8];
  endtask

  function automatic logic [15:0] get16(input logic [15:0] a);
    return {mem[a[8:0] + 9'd1], mem[a[8:0]]};
  endfunction

  task automatic do_reset(input bit check);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    if (check) chk(!bus_rd && !bus_wr && !halted, "R1 reset outputs",
                   {29'd0, bus_rd, bus_wr, halted}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic wait_fetch0(output bit found);
    found = 0;
    for (int i = 0; i < 12 && !found; i++) begin
      @(negedge clk);
      if (bus_rd && bus_addr == 16'h0000) found = 1;
    end
  endtask

  // {is_add, n, d, imm, operand, Rn init} in nibble-aligned fields
  localparam logic [51:0] VEC [0:6] = '{
    52'h0_1_0_80_0000_0000,
    52'h0_7_0_33_0000_0000,
    52'h1_4_6_00_12FF_0001,
    52'h1_0_0_00_FFFF_0002,
    52'h1_7_3_00_1200_0000,
    52'h0_0_0_FF_0000_ABCD,
    52'h1_2_7_00_00FF_0001
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit found;
    int base;
    rst_n    = 1'b0;
    ws_base  = WSB;
    idx_base = IXB;

    // R1: reset state and first fetch address
    clear_mem();
    mem[0] = 8'h50;
    do_reset(1);
    wait_fetch0(found);
    chk(found, "R1 first read at 0000", {16'd0, bus_addr}, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 7; v++) begin
      logic        is_add;
      logic [2:0]  n, d;
      logic [7:0]  imm;
      logic [15:0] opnd, rinit, rn_exp, r7_mid, pc_exp, rlo;
      int          cyc;
      is_add = VEC[v][48];
      n      = VEC[v][46:44];
      d      = VEC[v][42:40];
      imm    = VEC[v][39:32];
      opnd   = VEC[v][31:16];
      rinit  = VEC[v][15:0];
      rn_exp = is_add ? (opnd + rinit) : {8'h00, imm};
      r7_mid = (n == 3'd7) ? rn_exp : 16'h0000;
      pc_exp = {r7_mid[15:8], 8'h02};
      cyc    = is_add ? 15 : 10;
      rlo    = WSB + {12'd0, n, 1'b0};

      clear_mem();
      mem[0] = is_add ? (8'h60 | {5'd0, d}) : (8'h50 | {5'd0, n});
      mem[1] = is_add ? (8'h70 | {5'd0, n}) : imm;
      put16(rlo, rinit);
      put16(IXB + {13'd0, d}, opnd);
      do_reset(0);
      wait_fetch0(found);
      base = wr_total;
      repeat (cyc) @(negedge clk);
      chk(bus_rd && bus_addr == pc_exp, "R8 R6 next fetch time/address",
          {15'd0, bus_rd, bus_addr}, {15'd0, 1'b1, pc_exp});
      chk(wr_total - base == 4 && wr_log[base % 1024] == rlo &&
          wr_log[(base + 1) % 1024] == rlo + 16'd1, "R5 low then high write",
          {wr_log[base % 1024], wr_log[(base + 1) % 1024]}, {rlo, rlo + 16'd1});
      chk(wr_log[(base + 2) % 1024] == WSB + 16'd14 &&
          wr_log[(base + 3) % 1024] == WSB + 16'd15, "R6 R7 writeback order",
          {wr_log[(base + 2) % 1024], wr_log[(base + 3) % 1024]},
          {WSB + 16'd14, WSB + 16'd15});
      chk(get16(WSB + 16'd14) == pc_exp, "R6 R7 holds new PC",
          {16'd0, get16(WSB + 16'd14)}, {16'd0, pc_exp});
      if (n != 3'd7)
        chk(get16(rlo) == rn_exp, is_add ? "R4 add result" : "R3 load result",
            {16'd0, get16(rlo)}, {16'd0, rn_exp});
      chk(!halted, "R2 legal opcode not halted", {31'd0, halted}, 32'd0);
    end

    // R6 R7: low-byte wrap with no carry into PC high byte
    begin
      int odd_bad;
      int t_bad;
      odd_bad = 0;
      t_bad   = 0;
      clear_mem();
      for (int k = 0; k < 128; k++) begin
        mem[2 * k]     = 8'h51;
        mem[2 * k + 1] = k[7:0];
      end
      do_reset(0);
      wait_fetch0(found);
      for (int k = 1; k <= 128; k++) begin
        repeat (10) @(negedge clk);
        if (!(bus_rd && bus_addr == {8'h00, 8'((2 * k) % 256)})) t_bad++;
        if (bus_addr[0]) odd_bad++;
      end
      chk(odd_bad == 0, "R7 fetch addresses even", odd_bad, 0);
      chk(t_bad == 0, "R8 periodic fetch in long run", t_bad, 0);
      chk(bus_addr == 16'h0000, "R6 no carry into PC high", {16'd0, bus_addr}, 32'h0);
      chk(get16(WSB + 16'd2) == 16'h007F, "R3 last load into R1",
          {16'd0, get16(WSB + 16'd2)}, 32'h007F);
    end

    // R9: illegal first byte
    begin
      int busy;
      busy = 0;
      clear_mem();
      mem[0] = 8'hA5;
      put16(WSB, 16'h1234);
      do_reset(0);
      wait_fetch0(found);
      base = wr_total;
      @(negedge clk);
      chk(!halted, "R9 not halted at dispatch", {31'd0, halted}, 32'd0);
      @(negedge clk);
      chk(halted, "R9 halted two cycles after read", {31'd0, halted}, 32'd1);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (bus_rd || bus_wr || !halted) busy++;
      end
      chk(busy == 0, "R9 halted stays quiet", busy, 0);
      chk(wr_total == base && get16(WSB) == 16'h1234, "R9 no register change",
          {16'd0, get16(WSB)}, 32'h1234);
    end

    // R10: illegal second byte
    clear_mem();
    mem[0] = 8'h62;
    mem[1] = 8'h55;
    put16(WSB + 16'd10, 16'h1234);
    do_reset(0);
    wait_fetch0(found);
    base = wr_total;
    repeat (5) @(negedge clk);
    chk(!halted, "R10 not halted while second byte taken", {31'd0, halted}, 32'd0);
    @(negedge clk);
    chk(halted, "R10 halted after bad second byte", {31'd0, halted}, 32'd1);
    repeat (10) @(negedge clk);
    chk(wr_total == base, "R10 no register written", wr_total - base, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule